// File: doc/BRIEF.md
# DRAM PUF Challenge Sequencer

This controller drives a simple DRAM-style command port through the steps that turn cell-level manufacturing spread into a physically unclonable response. A run is launched by a one-cycle start pulse. It selects one row as the challenge and turns refresh off. It charges that row to all ones, then stresses it in one of three ways. It can wait out a programmable decay interval. It can hammer the physically adjacent rows. It can read the row back with a shortened, programmable sampling delay. After the stress it reads the row back and compares the data against the all-ones pattern. The positions that came back wrong form the response.

The response word (pattern XOR read data) leaves on a valid/ready stream with the challenge row attached. Once the consumer accepts the word, refresh is restored and a one-cycle done pulse ends the run. Stress counts and delays are sampled at start, so they may change freely between runs. A start that arrives while a run is in progress is dropped and tallied.

Top module: `dram_puf_seq`

## Requirements
- R1: After reset, busy, done and rsp_valid are 0, mem_ref_en is 1 and drop_cnt is 0.
- R2: A start while idle raises busy on the next cycle. For the whole run mem_ref_en stays 0 during every command. The first commands of a run are an activate and then exactly one write of all ones to the selected row.
- R3: In retention mode (mode 2'b00) the controller waits decay_cycles cycles after the write before reading back. Every bit read as 0 is reported as 1 in rsp_bits.
- R4: In hammer mode (mode 2'b01) the controller alternates between row-1 and row+1, each with hammer_count accesses. Each access is a cycle with mem_act and mem_rd both high. A neighbour that falls outside rows 0..ROWS-1 is skipped, and the PUF row itself is never hammered. The PUF row receives exactly two activates per run, one for the write and one for the readback.
- R5: In latency mode (mode 2'b10 or 2'b11) the read data is sampled fast_rd_delay cycles after the read command, with a value of 0 treated as 1. The other modes sample NORM_RD_LAT cycles after the read.
- R6: rsp_bits is the XOR of all ones with the sampled data, and rsp_row is the challenge row. Both, together with rsp_valid, hold steady while rsp_ready is low.
- R7: In the cycle after the rsp_valid/rsp_ready handshake, done is high for exactly one cycle. In that same cycle busy is low and mem_ref_en is 1.
- R8: A start while busy does not alter the running run. drop_cnt increments by one, wrapping modulo 2^DROP_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| start | input | 1 | launch pulse |
| mode | input | 2 | 00 retention, 01 hammer, 1x latency |
| row_sel | input | ROW_W | challenge row |
| decay_cycles | input | CNT_W | retention wait |
| hammer_count | input | CNT_W | accesses per neighbour row |
| fast_rd_delay | input | DLY_W | shortened sampling delay |
| busy | output | 1 | run in progress |
| done | output | 1 | end-of-run pulse |
| drop_cnt | output | DROP_W | starts ignored while busy |
| mem_ref_en | output | 1 | refresh enable |
| mem_act | output | 1 | row activate |
| mem_wr | output | 1 | write command |
| mem_rd | output | 1 | read command |
| mem_row | output | ROW_W | command row |
| mem_wdata | output | DATA_W | write data |
| mem_rdata | input | DATA_W | read data |
| rsp_valid | output | 1 | response available |
| rsp_ready | input | 1 | response accepted |
| rsp_row | output | ROW_W | challenge of the response |
| rsp_bits | output | DATA_W | bit-flip map |

## Verification
The read data is captured at the clock edge that closes the cycle lying D cycles after the read command, where D is the effective delay. rsp_valid then rises one cycle later. busy rises one cycle after an accepted start. done follows the handshake by one cycle. The bench drives and samples on the falling edge. Rather than fixing cycle counts for the stress windows, it polls for rsp_valid. It then checks done and busy on the very next falling edge, and the pulse's end on the one after that. Its memory model delivers correct data only from the third cycle after a read. This makes the sampling-delay rule visible in the response bits.

// File: rtl/dram_puf_seq.sv
module dram_puf_seq #(
  parameter int ROWS        = 8,
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 16,
  parameter int DLY_W       = 4,
  parameter int NORM_RD_LAT = 4,
  parameter int DROP_W      = 8,
  localparam int ROW_W      = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [ROW_W-1:0]  row_sel,
  input  logic [CNT_W-1:0]  decay_cycles,
  input  logic [CNT_W-1:0]  hammer_count,
  input  logic [DLY_W-1:0]  fast_rd_delay,
  output logic              busy,
  output logic              done,
  output logic [DROP_W-1:0] drop_cnt,
  output logic              mem_ref_en,
  output logic              mem_act,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic [ROW_W-1:0]  mem_row,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ROW_W-1:0]  rsp_row,
  output logic [DATA_W-1:0] rsp_bits
);
  typedef enum logic [3:0] {S_IDLE, S_ACTW, S_WR, S_WAIT, S_HAM,
                            S_ACTR, S_RD, S_RWAIT, S_OUT} st_t;

  st_t              st;
  logic [1:0]       mode_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] decay_q, ham_q, cnt;
  logic [DLY_W-1:0] fast_q, rd_lat;
  logic             phase, nb_ok;

  wire is_ret = mode_q == 2'b00;
  wire is_ham = mode_q == 2'b01;

  assign rd_lat = !mode_q[1] ? DLY_W'(NORM_RD_LAT) :
                  (fast_q == '0) ? DLY_W'(1) : fast_q;
  assign nb_ok  = phase ? (row_q != ROW_W'(ROWS-1)) : (row_q != '0);

  assign busy       = st != S_IDLE;
  assign mem_ref_en = st == S_IDLE;
  assign mem_wr     = st == S_WR;
  assign mem_wdata  = '1;
  assign mem_act    = st == S_ACTW || st == S_ACTR || (st == S_HAM && nb_ok);
  assign mem_rd     = st == S_RD || (st == S_HAM && nb_ok);
  assign mem_row    = (st != S_HAM) ? row_q :
                      phase ? row_q + 1'b1 : row_q - 1'b1;
  assign rsp_valid  = st == S_OUT;
  assign rsp_row    = row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      mode_q   <= '0;
      row_q    <= '0;
      decay_q  <= '0;
      ham_q    <= '0;
      fast_q   <= '0;
      cnt      <= '0;
      phase    <= 1'b0;
      rsp_bits <= '0;
      done     <= 1'b0;
      drop_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (start && st != S_IDLE) drop_cnt <= drop_cnt + 1'b1;
      case (st)
        S_IDLE: if (start) begin
          mode_q  <= mode;
          row_q   <= row_sel;
          decay_q <= decay_cycles;
          ham_q   <= hammer_count;
          fast_q  <= fast_rd_delay;
          st      <= S_ACTW;
        end
        S_ACTW: st <= S_WR;
        S_WR: begin
          cnt   <= '0;
          phase <= 1'b0;
          if (is_ret && decay_q != '0)      st <= S_WAIT;
          else if (is_ham && ham_q != '0)   st <= S_HAM;
          else                              st <= S_ACTR;
        end
        S_WAIT: begin
          cnt <= cnt + 1'b1;
          if (cnt == decay_q - 1'b1) st <= S_ACTR;
        end
        S_HAM: begin
          phase <= ~phase;
          if (phase) begin
            cnt <= cnt + 1'b1;
            if (cnt == ham_q - 1'b1) st <= S_ACTR;
          end
        end
        S_ACTR: st <= S_RD;
        S_RD: begin
          cnt <= '0;
          st  <= S_RWAIT;
        end
        S_RWAIT: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(rd_lat) - 1'b1) begin
            rsp_bits <= ~mem_rdata;
            st       <= S_OUT;
          end
        end
        S_OUT: if (rsp_ready) begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module dram_puf_seq_chk #(
  parameter int ROW_W  = 3,
  parameter int DATA_W = 16,
  parameter int DROP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [DROP_W-1:0] drop_cnt,
  input logic              mem_ref_en,
  input logic              mem_act,
  input logic              mem_wr,
  input logic              mem_rd,
  input logic [ROW_W-1:0]  mem_row,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ROW_W-1:0]  rsp_row,
  input logic [DATA_W-1:0] rsp_bits,
  input logic [ROW_W-1:0]  row_q
);
  // R2
  charge_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_wdata == '1 && !mem_ref_en && !mem_rd && !mem_act));
  // R4
  hammer_neighbour_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_act && mem_rd) |-> ({1'b0, mem_row} == {1'b0, row_q} + 1'b1 ||
                             {1'b0, mem_row} + 1'b1 == {1'b0, row_q}));
  // R6
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_bits) && $stable(rsp_row)));
  // R7
  done_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(rsp_valid && rsp_ready) && !busy && mem_ref_en));
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  drop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> drop_cnt == DROP_W'($past(drop_cnt) + 1'b1));
endmodule

bind dram_puf_seq dram_puf_seq_chk #(.ROW_W(ROW_W), .DATA_W(DATA_W), .DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .drop_cnt(drop_cnt), .mem_ref_en(mem_ref_en), .mem_act(mem_act),
  .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_row(mem_row), .mem_wdata(mem_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_row(rsp_row),
  .rsp_bits(rsp_bits), .row_q(row_q)
);

// File: tb/tb_dram_puf_seq.sv
`timescale 1ns/1ps
module tb_dram_puf_seq;
  localparam int ROWS = 8, DW = 16, CW = 16, DLW = 4, RW = 3;
  localparam int RET_T = 200, HAM_T = 16, SLOW = 3;

  logic clk = 0, rst_n = 0, start = 0, rsp_ready = 0, clr = 0;
  logic [1:0] mode = 0;
  logic [RW-1:0] row_sel = 0;
  logic [CW-1:0] decay_cycles = 0, hammer_count = 0;
  logic [DLW-1:0] fast_rd_delay = 0;
  logic busy, done, mem_ref_en, mem_act, mem_wr, mem_rd, rsp_valid;
  logic [7:0] drop_cnt;
  logic [RW-1:0] mem_row, rsp_row;
  logic [DW-1:0] mem_wdata, mem_rdata, rsp_bits;

  always #2.5 clk = ~clk;

  dram_puf_seq dut (.clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .row_sel(row_sel), .decay_cycles(decay_cycles), .hammer_count(hammer_count),
    .fast_rd_delay(fast_rd_delay), .busy(busy), .done(done), .drop_cnt(drop_cnt),
    .mem_ref_en(mem_ref_en), .mem_act(mem_act), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_row(mem_row), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_row(rsp_row), .rsp_bits(rsp_bits));

  function automatic logic [DW-1:0] ret_mask(int r); return 16'h0101 << r; endfunction
  function automatic logic [DW-1:0] ham_mask(int r); return 16'h1000 >> r; endfunction
  function automatic logic [DW-1:0] lat_mask(int r); return 16'h0F00 ^ 16'(r); endfunction

  // behavioural memory with weak cells
  logic [DW-1:0] mem [ROWS];
  int wr_time [ROWS], nb [ROWS], act_cnt [ROWS];
  int cyc = 0, age = 100, rd_row = 0, wr_cnt = 0, ref_bad = 0;
  logic [DW-1:0] snap = '0, v;
  initial for (int r = 0; r < ROWS; r++) begin mem[r] = '0; wr_time[r] = 0; nb[r] = 0; act_cnt[r] = 0; end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (clr) begin
      for (int r = 0; r < ROWS; r++) act_cnt[r] <= 0;
      wr_cnt <= 0; ref_bad <= 0;
    end else begin
      if (mem_act) act_cnt[mem_row] <= act_cnt[mem_row] + 1;
      if (mem_wr && mem_wdata == '1) wr_cnt <= wr_cnt + 1;
      if (mem_ref_en && (mem_act || mem_wr || mem_rd)) ref_bad <= ref_bad + 1;
    end
    if (mem_wr) begin mem[mem_row] <= mem_wdata; wr_time[mem_row] <= cyc; nb[mem_row] <= 0; end
    if (mem_act && mem_rd)
      for (int r = 0; r < ROWS; r++)
        if (r == int'(mem_row) + 1 || r + 1 == int'(mem_row)) nb[r] <= nb[r] + 1;
    if (mem_rd) begin
      v = mem[mem_row];
      if (cyc - wr_time[mem_row] >= RET_T) v = v & ~ret_mask(int'(mem_row));
      if (nb[mem_row] >= HAM_T) v = v & ~ham_mask(int'(mem_row));
      snap <= v; rd_row <= int'(mem_row); age <= 1;
    end else if (age < 100) age <= age + 1;
  end
  assign mem_rdata = (age < SLOW) ? snap ^ lat_mask(rd_row) : snap;

  int checks = 0, errors = 0;
  bit finished = 0;
  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  typedef struct packed {
    logic [1:0] md; logic [2:0] row; logic [15:0] dec; logic [15:0] ham; logic [3:0] fst; logic [1:0] kind;
  } vec_t;
  // kind: 0 none, 1 retention mask, 2 hammer mask, 3 latency mask
  localparam vec_t VECS [10] = '{
    '{2'b00, 3'd2, 16'd10,  16'd0,  4'd0, 2'd0},
    '{2'b00, 3'd5, 16'd250, 16'd0,  4'd0, 2'd1},
    '{2'b01, 3'd3, 16'd0,   16'd4,  4'd0, 2'd0},
    '{2'b01, 3'd4, 16'd0,   16'd10, 4'd0, 2'd2},
    '{2'b01, 3'd0, 16'd0,   16'd10, 4'd0, 2'd0},
    '{2'b01, 3'd0, 16'd0,   16'd20, 4'd0, 2'd2},
    '{2'b01, 3'd7, 16'd0,   16'd20, 4'd0, 2'd2},
    '{2'b10, 3'd1, 16'd0,   16'd0,  4'd2, 2'd3},
    '{2'b10, 3'd6, 16'd0,   16'd0,  4'd3, 2'd0},
    '{2'b11, 3'd2, 16'd0,   16'd0,  4'd0, 2'd3}
  };

  task automatic launch(vec_t t);
    @(negedge clk);
    mode = t.md; row_sel = t.row; decay_cycles = t.dec; hammer_count = t.ham;
    fast_rd_delay = t.fst; start = 1; clr = 1;
    @(negedge clk);
    start = 0; clr = 0;
    chk(busy === 1'b1, "R2 busy after start", busy, 1);
  endtask

  task automatic finish_run(vec_t t, string req);
    logic [DW-1:0] exp;
    int r = int'(t.row);
    while (rsp_valid !== 1'b1) @(negedge clk);
    case (t.kind)
      2'd1: exp = ret_mask(r);
      2'd2: exp = ham_mask(r);
      2'd3: exp = lat_mask(r);
      default: exp = '0;
    endcase
    chk(rsp_bits === exp, req, rsp_bits, exp);
    chk(rsp_row === t.row, "R6 response row", rsp_row, t.row);
    chk(ref_bad == 0 && wr_cnt == 1, "R2 refresh off and single all-ones write", ref_bad, 0);
    chk(act_cnt[r] == 2, "R4 PUF row activates", act_cnt[r], 2);
    for (int n = 0; n < ROWS; n++)
      if (n != r) begin
        int e = (t.md == 2'b01 && (n == r - 1 || n == r + 1)) ? int'(t.ham) : 0;
        chk(act_cnt[n] == e, "R4 neighbour hammer count", act_cnt[n], e);
      end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk(done === 1'b1 && busy === 1'b0 && mem_ref_en === 1'b1, "R7 done with refresh back", {done, busy, mem_ref_en}, 3'b101);
    @(negedge clk);
    chk(done === 1'b0, "R7 done single pulse", done, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 0 && done === 0 && rsp_valid === 0 && mem_ref_en === 1 && drop_cnt === 0,
        "R1 reset state", {busy, done, rsp_valid, mem_ref_en}, 4'b0001);

    for (int i = 0; i < 10; i++) begin
      launch(VECS[i]);
      finish_run(VECS[i], VECS[i].md == 2'b00 ? "R3 retention map" :
                          VECS[i].md == 2'b01 ? "R4 hammer map" : "R5 latency map");
    end

    // R5: zero fast delay acts as one
    begin
      vec_t t = '{2'b10, 3'd3, 16'd0, 16'd0, 4'd0, 2'd3};
      launch(t); finish_run(t, "R5 zero delay");
    end

    // R6: backpressure holds the response
    begin
      vec_t t = '{2'b00, 3'd6, 16'd220, 16'd0, 4'd0, 2'd1};
      logic [DW-1:0] b0;
      launch(t);
      while (rsp_valid !== 1'b1) @(negedge clk);
      b0 = rsp_bits;
      repeat (4) @(negedge clk);
      chk(rsp_valid === 1'b1 && rsp_bits === b0, "R6 held under backpressure", rsp_bits, b0);
      finish_run(t, "R6 map after stall");
    end

    // R8: start while busy is dropped
    begin
      vec_t t = '{2'b00, 3'd1, 16'd30, 16'd0, 4'd0, 2'd0};
      launch(t);
      @(negedge clk); row_sel = 3'd6; mode = 2'b01; start = 1;
      @(negedge clk); start = 0;
      chk(drop_cnt === 8'd1, "R8 drop count", drop_cnt, 1);
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
      chk(drop_cnt === 8'd2, "R8 drop count again", drop_cnt, 2);
      finish_run(t, "R8 run unaffected");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule